// File: doc/BRIEF.md
# Programmable Square Wave Rate Divider

This block derives a family of low-rate timing signals from a 32.768 kHz reference. The reference arrives as a level on `ref_in`, sampled in the system clock domain. Each rising edge of the reference advances a binary divider chain, and a 4-bit rate code picks one stage of that chain through a 16-way selector. The selected stage drives the square-wave output pin. It also produces a one-cycle periodic-event pulse at each rising edge of the selected stage, which gives one pulse per output period.

A 3-bit oscillator field decides whether the divider runs, is held, or is stopped. Whenever the divider is not running it is held cleared, so restarting it always begins a fresh phase. An output enable gates the pin. A second enable, honoured only in one oscillator setting, routes the raw reference to the pin in place of the divided tap; the periodic-event rate is not changed by this. The last divider stage produces a one-cycle 1 Hz update tick.

Top module: `sqw_rate_divider`

## Requirements
- R1: While `rst` is high, `sq_out`, `per_pulse` and `tick_1hz` are all low.
- R2: Rate codes 1 and 2 give 256 Hz and 128 Hz, i.e. periods of 128 and 256 reference periods.
- R3: Rate codes 3 to 7 give 8.192, 4.096, 2.048, 1.024 kHz and 512 Hz: periods of 4, 8, 16, 32 and 64 reference periods.
- R4: Rate codes 8 to 15 give 256 Hz down to 2 Hz, halving at each step: a period of 128·2^(code−8) reference periods.
- R5: Rate code 0 produces no periodic pulse, and the pin stays low.
- R6: `per_pulse` is high for exactly one clock, once per selected period, in the same cycle in which `sq_out` rises (when the pin is enabled and not bypassed).
- R7: Oscillator field 3'b010 or 3'b011 runs the divider. 3'b110 and 3'b111 hold it, and any other value stops it. In the held and stopped states the divider is cleared, and no pulse or tick occurs.
- R8: With `sq_en` low, `sq_out` is low the next cycle and stays low. Periodic pulses continue at the selected rate.
- R9: With the oscillator field at 3'b011, `sq_en` high and `k32_en` high, `sq_out` equals the value of `ref_in` one clock earlier. Under any other oscillator value, `k32_en` has no effect.
- R10: The periodic pulse interval in the raw-reference mode is the same as for the selected rate code.
- R11: `tick_1hz` pulses for one clock each 32768 reference periods (2^DIV_W), the first one 32768 reference periods after the divider starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | 32.768 kHz reference level, synchronous to clk |
| rate_code | input | 4 | Tap selection code |
| osc_ctl | input | 3 | Oscillator / divider control field |
| sq_en | input | 1 | Square-wave pin enable |
| k32_en | input | 1 | Raw-reference enable (honoured only with osc_ctl = 3'b011) |
| sq_out | output | 1 | Square-wave pin, registered |
| per_pulse | output | 1 | One-cycle periodic-event pulse, registered |
| tick_1hz | output | 1 | One-cycle 1 Hz update tick, registered |

## Verification
A divider that miscounts or has a wrong tap mapping shows up as a wrong gap between two periodic pulses. The gap is checked to the exact clock, so the fault is reported within two output periods of the rate under test. A clear that fails on hold or stop would leave pulses or pin activity during a window in which both must be absent. A wrong final stage moves the first 1 Hz tick after restart. The raw-reference path is compared with the reference cycle by cycle, so a misrouted bypass fails at its first sample.

// File: rtl/sqw_rate_pkg.sv
package sqw_rate_pkg;
  localparam int NUM_CODES = 16;
  localparam logic [2:0] OSC_RUN     = 3'b010;
  localparam logic [2:0] OSC_RUN_RAW = 3'b011;

  // divider stage driving a given rate code; stage n has period 2^(n+1) refs
  function automatic int tap_index(int code);
    if (code >= 3) return code - 2;
    else           return code + 5;
  endfunction
endpackage

// File: rtl/sqw_div_chain.sv
module sqw_div_chain #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [DIV_W-1:0] cnt,
  output logic             tick
);
  localparam int MSB = DIV_W - 1;
  logic msb_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      msb_q <= 1'b0;
      tick  <= 1'b0;
    end else begin
      if (inc) cnt <= cnt + 1'b1;
      msb_q <= cnt[MSB];
      tick  <= msb_q & ~cnt[MSB];
    end
  end

  // R7
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R11
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sqw_tap_mux.sv
module sqw_tap_mux
  import sqw_rate_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic [DIV_W-1:0]  cnt,
  input  logic [RATE_W-1:0] code,
  output logic              tap
);
  logic [NUM_CODES-1:0] taps;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign taps[c] = 1'b0;
    end else begin : g_on
      localparam int IDX = tap_index(c);
      assign taps[c] = cnt[IDX];
    end
  end

  assign tap = taps[code];
endmodule

// File: rtl/sqw_out_stage.sv
module sqw_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tap,
  input  logic sq_en,
  input  logic bypass,
  input  logic ref_in,
  output logic sq_out,
  output logic per_pulse
);
  logic tap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q     <= 1'b0;
      per_pulse <= 1'b0;
      sq_out    <= 1'b0;
    end else begin
      tap_q     <= run & tap;
      per_pulse <= run & tap & ~tap_q;
      sq_out    <= bypass ? ref_in : (sq_en & run & tap);
    end
  end

  // R8
  sq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sq_en |=> !sq_out);
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    per_pulse |=> !per_pulse);
  // R6
  pulse_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_en && !bypass) |=> (per_pulse -> sq_out));
  // R9
  byp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (sq_out == $past(ref_in)));
endmodule

// File: rtl/sqw_rate_divider.sv
module sqw_rate_divider
  import sqw_rate_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4,
  parameter int OSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [OSC_W-1:0]  osc_ctl,
  input  logic              sq_en,
  input  logic              k32_en,
  output logic              sq_out,
  output logic              per_pulse,
  output logic              tick_1hz
);
  logic             ref_q;
  logic             ref_rise;
  logic             run;
  logic             bypass;
  logic             tap;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_in;
  end

  assign ref_rise = ref_in & ~ref_q;
  assign run      = (osc_ctl == OSC_RUN) || (osc_ctl == OSC_RUN_RAW);
  assign bypass   = (osc_ctl == OSC_RUN_RAW) && sq_en && k32_en;

  sqw_div_chain #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run),
    .inc  (ref_rise),
    .cnt  (cnt),
    .tick (tick_1hz)
  );

  sqw_tap_mux #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_mux (
    .cnt  (cnt),
    .code (rate_code),
    .tap  (tap)
  );

  sqw_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tap       (tap),
    .sq_en     (sq_en),
    .bypass    (bypass),
    .ref_in    (ref_in),
    .sq_out    (sq_out),
    .per_pulse (per_pulse)
  );

  // R5
  code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> !per_pulse);
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!per_pulse && !tick_1hz && !sq_out));
endmodule

// File: tb/sqw_rate_divider_bench.sv
module sqw_rate_divider_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic [3:0] rate_code = '0;
  logic [2:0] osc_ctl = '0;
  logic       sq_en = 1'b0;
  logic       k32_en = 1'b0;
  logic       sq_out, per_pulse, tick_1hz;

  sqw_rate_divider u_sqw_rate_divider (
    .clk(clk), .rst(rst), .ref_in(ref_in), .rate_code(rate_code),
    .osc_ctl(osc_ctl), .sq_en(sq_en), .k32_en(k32_en),
    .sq_out(sq_out), .per_pulse(per_pulse), .tick_1hz(tick_1hz)
  );

  always #10 clk = ~clk;
  always @(negedge clk) ref_in <= ~ref_in;

  typedef struct { int gap; string req; bit sq_hi; bit sq_chk; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, cyc = 0, last_pulse = 0, pulse_cnt = 0, tick_cnt = 0;
  bit have_last = 0, prev_pulse = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (cyc > 190000) begin
      check(0, "watchdog", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
    if (per_pulse) begin
      pulse_cnt++;
      if (prev_pulse) check(0, "R6 pulse longer than one cycle", 2, 1);
      if (have_last && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(cyc - last_pulse == e.gap, e.req, cyc - last_pulse, e.gap);
        if (e.sq_chk) check(sq_out == e.sq_hi, {e.req, " R6 pin level at pulse"}, int'(sq_out), int'(e.sq_hi));
      end
      last_pulse = cyc;
      have_last  = 1;
    end
    prev_pulse = per_pulse;
    if (tick_1hz) tick_cnt++;
  end

  // reference periods per output period, from the rate table
  function automatic int ref_periods(int code);
    case (code)
      1: return 128;
      2: return 256;
      3: return 4;
      4: return 8;
      5: return 16;
      6: return 32;
      7: return 64;
      default: return 128 << (code - 8);
    endcase
  endfunction

  task automatic run_rate(int code, logic [2:0] osc, bit en, bit k32, int n, string req, bit sq_chk);
    int gap, limit, w;
    osc_ctl = 3'b000;
    repeat (3) @(negedge clk);
    have_last = 0;
    rate_code = code[3:0]; sq_en = en; k32_en = k32; osc_ctl = osc;
    gap = 2 * ref_periods(code);
    for (int i = 0; i < n; i++) exp_q.push_back('{gap, req, en, sq_chk});
    limit = gap * (n + 1) + 50;
    w = 0;
    while (exp_q.size() > 0 && w < limit) begin
      @(negedge clk);
      w++;
    end
    if (exp_q.size() > 0) begin
      check(0, {req, " timeout"}, exp_q.size(), 0);
      exp_q.delete();
    end
    osc_ctl = 3'b000;
  endtask

  task automatic quiet_window(logic [2:0] osc, logic [3:0] code, bit k32, string req);
    int pc, highs;
    osc_ctl = 3'b000;
    repeat (3) @(negedge clk);
    rate_code = code; sq_en = 1; k32_en = k32; osc_ctl = osc;
    repeat (3) @(negedge clk);
    pc = pulse_cnt; highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sq_out) highs++;
    end
    check(pulse_cnt == pc, {req, " pulses"}, pulse_cnt - pc, 0);
    check(highs == 0, {req, " pin high cycles"}, highs, 0);
    osc_ctl = 3'b000;
  endtask

  initial begin
    int st, tc, w, d;
    osc_ctl = 3'b010; rate_code = 4'd3; sq_en = 1;
    repeat (4) @(negedge clk);
    check(sq_out == 0, "R1 sq_out in reset", int'(sq_out), 0);
    check(per_pulse == 0, "R1 per_pulse in reset", int'(per_pulse), 0);
    check(tick_1hz == 0, "R1 tick_1hz in reset", int'(tick_1hz), 0);
    rst = 0;

    run_rate(1, 3'b010, 1, 0, 2, "R2 code 1", 1);
    run_rate(2, 3'b010, 1, 0, 2, "R2 code 2", 1);
    run_rate(3, 3'b010, 1, 0, 2, "R3 code 3", 1);
    run_rate(5, 3'b010, 1, 0, 2, "R3 code 5", 1);
    run_rate(7, 3'b010, 1, 0, 2, "R3 code 7", 1);
    run_rate(8, 3'b010, 1, 0, 2, "R4 code 8", 1);
    run_rate(10, 3'b010, 1, 0, 2, "R4 code 10", 1);
    run_rate(13, 3'b010, 1, 0, 1, "R4 code 13", 1);
    run_rate(4, 3'b010, 0, 0, 2, "R8 pin disabled", 1);
    run_rate(6, 3'b011, 1, 0, 2, "R7 run with 011", 1);
    run_rate(8, 3'b011, 1, 1, 2, "R10 raw mode rate", 0);

    // R9: raw reference on the pin
    osc_ctl = 3'b000;
    repeat (3) @(negedge clk);
    rate_code = 4'd8; sq_en = 1; k32_en = 1; osc_ctl = 3'b011;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(sq_out == ref_in, "R9 pin follows reference", int'(sq_out), int'(ref_in));
    end

    quiet_window(3'b010, 4'd0, 1, "R9 R5 k32 ignored, code zero");
    quiet_window(3'b110, 4'd3, 0, "R7 hold 110");
    quiet_window(3'b111, 4'd3, 0, "R7 hold 111");
    quiet_window(3'b001, 4'd3, 1, "R7 stopped 001");

    // R11: first tick after a fresh start
    osc_ctl = 3'b000; rate_code = 4'd0;
    repeat (3) @(negedge clk);
    tc = tick_cnt;
    osc_ctl = 3'b010;
    st = cyc;
    w = 0;
    while (tick_cnt == tc && w < 70000) begin
      @(negedge clk);
      w++;
    end
    d = cyc - st;
    check(d >= 65532 && d <= 65540, "R11 first tick after start", d, 65536);
    @(negedge clk);
    check(tick_1hz == 0, "R11 tick one cycle", int'(tick_1hz), 0);
    osc_ctl = 3'b000;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule